// File: doc/BRIEF.md
# Multi-source bus master request interface

This block lets several internal requesters share one pipelined system bus master port. Each source is one of a group of channel move engines, a debug access source or a serial-link source. A source hands over a single read or write of 8, 16 or 32 bits, with a priority level. The block holds the transfer in a one-entry slot for that source and competes for the bus on the source's behalf.

The address phase is presented with a request and a priority level. It is transferred on a clock edge where the bus grants. The bus may then answer each issued transfer at any later cycle, in any order. Every transfer carries its source index as a tag. The answer, whether data or error, goes back to the source named by the tag, so a slow access from one source never holds up another.

A retry answer does not complete the transfer. The block puts the transfer back in its slot unchanged and withdraws the bus request for a cycle. It then presents the transfer again, so the bus is never held by a source that is being refused.

Top module: `bmr_master`

## Requirements
- R1: After reset, bus_req_o is 0, every src_ready_o bit is 1 and src_rsp_valid_o is 0.
- R2: A source's transfer is taken on an edge where src_valid_i and src_ready_o are both 1 for it. From the next cycle, src_ready_o for that source stays 0 until the source's transfer has been answered with a code other than retry. Each source therefore has at most one transfer outstanding.
- R3: The presented address phase carries the source's address, write flag, write data, size (0 = 8 bit, 1 = 16 bit, 2 = 32 bit) and priority (0 = low, 1 = medium, 2 = high). bus_tag_o equals the source index. The transfer is issued on an edge where bus_req_o and bus_gnt_i are both 1.
- R4: Among waiting transfers, the one with the highest priority level is presented first.
- R5: When waiting transfers tie on priority, the first source after the last granted one, counting upward and wrapping, is presented. Directly after reset, source 0 counts first.
- R6: While bus_req_o is 1 and bus_gnt_i is 0, the next cycle still requests with the same tag, address, size, priority, write flag and write data, even if a higher-priority transfer arrives.
- R7: A bus response with a code other than retry, for a tag whose transfer is outstanding, raises only src_rsp_valid_o[tag] in the same cycle. src_rsp_rdata_o carries bus_rsp_rdata_i, and src_rsp_err_o is 1 exactly when the code is 1 (error). Codes 0 and 3 mean success.
- R8: Responses may arrive in a different order from the issue order, and each is routed to its own source.
- R9: A response with code 2 (retry) produces no source response. In the following cycle, bus_req_o is 0, unless an address phase presented earlier is still waiting for grant. The retried transfer is not presented in that cycle. It is presented again afterwards with unchanged address, size, priority and tag.
- R10: A bus response whose tag has no outstanding transfer is ignored: no source response is raised and that source stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_valid_i | input | N_SRC | Per-source transfer offer |
| src_ready_o | output | N_SRC | Per-source slot free |
| src_we_i | input | N_SRC | Per-source write flag |
| src_size_i | input | N_SRC x 2 | Per-source size code |
| src_prio_i | input | N_SRC x 2 | Per-source priority code |
| src_addr_i | input | N_SRC x AW | Per-source address |
| src_wdata_i | input | N_SRC x DW | Per-source write data |
| src_rsp_valid_o | output | N_SRC | Per-source response strobe |
| src_rsp_err_o | output | 1 | Response is an error |
| src_rsp_rdata_o | output | DW | Response read data |
| bus_req_o | output | 1 | Bus request |
| bus_prio_o | output | 2 | Request priority level |
| bus_gnt_i | input | 1 | Bus grant, address phase accepted |
| bus_addr_o | output | AW | Address phase address |
| bus_we_o | output | 1 | Address phase write flag |
| bus_size_o | output | 2 | Address phase size code |
| bus_wdata_o | output | DW | Write data |
| bus_tag_o | output | TW | Source tag of the address phase |
| bus_rsp_valid_i | input | 1 | Bus response strobe |
| bus_rsp_tag_i | input | TW | Tag of the response |
| bus_rsp_code_i | input | 2 | 0 ok, 1 error, 2 retry, 3 ok |
| bus_rsp_rdata_i | input | DW | Response read data |

## Verification
Suppose a slot is left in the wrong state. The source's ready bit then goes wrong in the cycle after the faulty edge. That shows up as a stuck ready, a lost response or a response sent to a source that has nothing outstanding. Suppose instead the round-robin pointer or the grant lock goes wrong. The tag presented at the next grant then differs from the expected order. If the retry back-off fails, bus_req_o is already seen high in the cycle after the retry. The scoreboard also catches any response that is misrouted or out of turn in the cycle it appears.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_OUT  = 2'd2
  } slot_st_e;

  localparam logic [1:0] RSP_ERR   = 2'd1;
  localparam logic [1:0] RSP_RETRY = 2'd2;
endpackage

// File: rtl/bmr_slot.sv
module bmr_slot
  import bmr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          issue_i,
  input  logic          rsp_hit_i,
  input  logic          retry_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    prio_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output slot_st_e      st_o,
  output logic          we_o,
  output logic [1:0]    size_o,
  output logic [1:0]    prio_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  slot_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SLOT_IDLE;
      we_o    <= 1'b0;
      size_o  <= '0;
      prio_o  <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      unique case (st_q)
        SLOT_IDLE: if (take_i) begin
          st_q    <= SLOT_PEND;
          we_o    <= we_i;
          size_o  <= size_i;
          prio_o  <= prio_i;
          addr_o  <= addr_i;
          wdata_o <= wdata_i;
        end
        SLOT_PEND: if (issue_i) st_q <= SLOT_OUT;
        SLOT_OUT:  if (rsp_hit_i) st_q <= retry_i ? SLOT_PEND : SLOT_IDLE;
        default:   st_q <= SLOT_IDLE;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/bmr_arb.sv
module bmr_arb #(
  parameter int N_SRC = 6,
  localparam int TW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]      pend_i,
  input  logic [N_SRC-1:0][1:0] prio_i,
  input  logic [TW-1:0]         rr_i,
  input  logic                  lock_vld_i,
  input  logic [TW-1:0]         lock_idx_i,
  output logic [TW-1:0]         sel_o,
  output logic                  any_o
);
  logic [1:0] max_p;
  logic       found;

  always_comb begin
    max_p = 2'd0;
    for (int i = 0; i < N_SRC; i++)
      if (pend_i[i] && prio_i[i] > max_p) max_p = prio_i[i];
    found = 1'b0;
    sel_o = '0;
    for (int k = 1; k <= N_SRC; k++) begin
      automatic int j = int'(rr_i) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!found && pend_i[j] && prio_i[j] == max_p) begin
        found = 1'b1;
        sel_o = j[TW-1:0];
      end
    end
    if (lock_vld_i) sel_o = lock_idx_i;
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/bmr_master.sv
module bmr_master
  import bmr_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int TW = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_valid_i,
  output logic [N_SRC-1:0]       src_ready_o,
  input  logic [N_SRC-1:0]       src_we_i,
  input  logic [N_SRC-1:0][1:0]  src_size_i,
  input  logic [N_SRC-1:0][1:0]  src_prio_i,
  input  logic [N_SRC-1:0][AW-1:0] src_addr_i,
  input  logic [N_SRC-1:0][DW-1:0] src_wdata_i,
  output logic [N_SRC-1:0]       src_rsp_valid_o,
  output logic                   src_rsp_err_o,
  output logic [DW-1:0]          src_rsp_rdata_o,
  output logic                   bus_req_o,
  output logic [1:0]             bus_prio_o,
  input  logic                   bus_gnt_i,
  output logic [AW-1:0]          bus_addr_o,
  output logic                   bus_we_o,
  output logic [1:0]             bus_size_o,
  output logic [DW-1:0]          bus_wdata_o,
  output logic [TW-1:0]          bus_tag_o,
  input  logic                   bus_rsp_valid_i,
  input  logic [TW-1:0]          bus_rsp_tag_i,
  input  logic [1:0]             bus_rsp_code_i,
  input  logic [DW-1:0]          bus_rsp_rdata_i
);
  slot_st_e                  st     [N_SRC];
  logic [N_SRC-1:0]          we_a;
  logic [N_SRC-1:0][1:0]     size_a;
  logic [N_SRC-1:0][1:0]     prio_a;
  logic [N_SRC-1:0][AW-1:0]  addr_a;
  logic [N_SRC-1:0][DW-1:0]  wdata_a;
  logic [N_SRC-1:0]          pend, rsp_hit, retry_hit;
  logic [TW-1:0]             sel, rr_q, lock_idx_q;
  logic                      any_pend, lock_vld_q, hold_q, issue;
  logic                      is_retry;

  assign is_retry = bus_rsp_code_i == RSP_RETRY;

  for (genvar i = 0; i < N_SRC; i++) begin : g_slot
    assign pend[i]      = st[i] == SLOT_PEND;
    assign src_ready_o[i] = st[i] == SLOT_IDLE;
    assign rsp_hit[i]   = bus_rsp_valid_i && bus_rsp_tag_i == TW'(i) && st[i] == SLOT_OUT;
    assign retry_hit[i] = rsp_hit[i] && is_retry;
    assign src_rsp_valid_o[i] = rsp_hit[i] && !is_retry;

    bmr_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (src_valid_i[i]),
      .issue_i  (issue && sel == TW'(i)),
      .rsp_hit_i(rsp_hit[i]),
      .retry_i  (is_retry),
      .we_i     (src_we_i[i]),
      .size_i   (src_size_i[i]),
      .prio_i   (src_prio_i[i]),
      .addr_i   (src_addr_i[i]),
      .wdata_i  (src_wdata_i[i]),
      .st_o     (st[i]),
      .we_o     (we_a[i]),
      .size_o   (size_a[i]),
      .prio_o   (prio_a[i]),
      .addr_o   (addr_a[i]),
      .wdata_o  (wdata_a[i])
    );
  end

  bmr_arb #(.N_SRC(N_SRC)) u_arb (
    .pend_i    (pend),
    .prio_i    (prio_a),
    .rr_i      (rr_q),
    .lock_vld_i(lock_vld_q),
    .lock_idx_i(lock_idx_q),
    .sel_o     (sel),
    .any_o     (any_pend)
  );

  // back off one cycle after a retry unless an address phase is already on the bus
  assign bus_req_o = any_pend && (lock_vld_q || !hold_q);
  assign issue     = bus_req_o && bus_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q       <= TW'(N_SRC - 1);
      lock_vld_q <= 1'b0;
      lock_idx_q <= '0;
      hold_q     <= 1'b0;
    end else begin
      hold_q <= |retry_hit;
      if (issue) begin
        rr_q       <= sel;
        lock_vld_q <= 1'b0;
      end else if (bus_req_o) begin
        lock_vld_q <= 1'b1;
        lock_idx_q <= sel;
      end
    end
  end

  assign bus_tag_o       = sel;
  assign bus_addr_o      = addr_a[sel];
  assign bus_we_o        = we_a[sel];
  assign bus_size_o      = size_a[sel];
  assign bus_prio_o      = prio_a[sel];
  assign bus_wdata_o     = wdata_a[sel];
  assign src_rsp_err_o   = bus_rsp_code_i == RSP_ERR;
  assign src_rsp_rdata_o = bus_rsp_rdata_i;
endmodule

// File: rtl/bmr_master_chk.sv
module bmr_master_chk #(
  parameter int N_SRC = 6,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int TW = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_valid_i,
  input logic [N_SRC-1:0] src_ready_o,
  input logic [N_SRC-1:0] src_rsp_valid_o,
  input logic             bus_req_o,
  input logic             bus_gnt_i,
  input logic [1:0]       bus_prio_o,
  input logic [AW-1:0]    bus_addr_o,
  input logic             bus_we_o,
  input logic [1:0]       bus_size_o,
  input logic [DW-1:0]    bus_wdata_o,
  input logic [TW-1:0]    bus_tag_o,
  input logic             bus_rsp_valid_i,
  input logic [TW-1:0]    bus_rsp_tag_i,
  input logic [1:0]       bus_rsp_code_i,
  input logic [N_SRC-1:0] retry_hit
);
  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_tag_o) && $stable(bus_addr_o)
      && $stable(bus_prio_o) && $stable(bus_size_o) && $stable(bus_we_o) && $stable(bus_wdata_o));

  assert_retry_backoff_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|retry_hit) |=> !(bus_req_o && bus_tag_o == $past(bus_rsp_tag_i)));

  assert_rsp_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_rsp_valid_o));

  assert_rsp_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_rsp_valid_o) |-> src_rsp_valid_o == (N_SRC'(1) << bus_rsp_tag_i));

  assert_rsp_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_rsp_valid_o) |-> bus_rsp_valid_i && bus_rsp_code_i != 2'd2);

  assert_size_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_size_o != 2'd3);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assert_one_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_valid_i[i] && src_ready_o[i] |=> !src_ready_o[i]);
  end
endmodule

bind bmr_master bmr_master_chk #(.N_SRC(N_SRC), .AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .src_valid_i    (src_valid_i),
  .src_ready_o    (src_ready_o),
  .src_rsp_valid_o(src_rsp_valid_o),
  .bus_req_o      (bus_req_o),
  .bus_gnt_i      (bus_gnt_i),
  .bus_prio_o     (bus_prio_o),
  .bus_addr_o     (bus_addr_o),
  .bus_we_o       (bus_we_o),
  .bus_size_o     (bus_size_o),
  .bus_wdata_o    (bus_wdata_o),
  .bus_tag_o      (bus_tag_o),
  .bus_rsp_valid_i(bus_rsp_valid_i),
  .bus_rsp_tag_i  (bus_rsp_tag_i),
  .bus_rsp_code_i (bus_rsp_code_i),
  .retry_hit      (retry_hit)
);

// File: tb/bmr_master_tb.sv
module bmr_master_tb;
  localparam int N = 6;
  localparam int TW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]        s_valid = '0, s_we = '0;
  logic [N-1:0][1:0]   s_size = '0, s_prio = '0;
  logic [N-1:0][31:0]  s_addr = '0, s_wdata = '0;
  logic [N-1:0]        s_ready, r_valid;
  logic                r_err, b_req, b_we, b_gnt = 1'b0;
  logic [31:0]         r_rdata, b_addr, b_wdata;
  logic [1:0]          b_prio, b_size;
  logic [TW-1:0]       b_tag;
  logic                rv = 1'b0;
  logic [TW-1:0]       rtag = '0;
  logic [1:0]          rcode = '0;
  logic [31:0]         rdata = '0;

  bmr_master #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(s_valid), .src_ready_o(s_ready), .src_we_i(s_we),
    .src_size_i(s_size), .src_prio_i(s_prio), .src_addr_i(s_addr), .src_wdata_i(s_wdata),
    .src_rsp_valid_o(r_valid), .src_rsp_err_o(r_err), .src_rsp_rdata_o(r_rdata),
    .bus_req_o(b_req), .bus_prio_o(b_prio), .bus_gnt_i(b_gnt), .bus_addr_o(b_addr),
    .bus_we_o(b_we), .bus_size_o(b_size), .bus_wdata_o(b_wdata), .bus_tag_o(b_tag),
    .bus_rsp_valid_i(rv), .bus_rsp_tag_i(rtag), .bus_rsp_code_i(rcode), .bus_rsp_rdata_i(rdata)
  );

  int total = 0, fails = 0;
  typedef struct { int src; logic [31:0] data; logic err; } exp_t;
  exp_t q[$];
  int g_tag;
  logic [31:0] g_addr, g_wdata;
  logic [1:0] g_size, g_prio;
  logic g_we;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pops the scoreboard on every source response
  always @(posedge clk) begin
    if (rst_n && |r_valid) begin
      if (q.size() == 0) begin
        chk(0, "R10", "unexpected response", longint'(r_valid), 0);
      end else begin
        automatic exp_t e = q.pop_front();
        chk(r_valid == (N'(1) << e.src), "R8", "response source", longint'(r_valid), longint'(N'(1) << e.src));
        chk(r_rdata == e.data, "R7", "response data", r_rdata, e.data);
        chk(r_err == e.err, "R7", "response error", r_err, e.err);
      end
    end
  end

  task automatic setsrc(int i, bit we, int size, int prio, logic [31:0] a, logic [31:0] d);
    s_we[i] = we; s_size[i] = 2'(size); s_prio[i] = 2'(prio); s_addr[i] = a; s_wdata[i] = d;
  endtask

  task automatic fire(logic [N-1:0] m);
    s_valid = m;
    @(negedge clk);
    s_valid = '0;
  endtask

  task automatic grant_one(string req);
    chk(b_req == 1'b1, req, "request before grant", b_req, 1);
    g_tag = int'(b_tag); g_addr = b_addr; g_size = b_size; g_prio = b_prio;
    g_we = b_we; g_wdata = b_wdata;
    b_gnt = 1'b1;
    @(negedge clk);
    b_gnt = 1'b0;
  endtask

  task automatic respond(int tag, int code, logic [31:0] d, bit push);
    rv = 1'b1; rtag = TW'(tag); rcode = 2'(code); rdata = d;
    if (push) q.push_back('{src: tag, data: d, err: (code == 1)});
    @(negedge clk);
    rv = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(b_req == 1'b0, "R1", "bus_req after reset", b_req, 0);
    chk(s_ready == '1, "R1", "ready after reset", s_ready, '1);
    chk(r_valid == '0, "R1", "rsp after reset", r_valid, 0);

    // R2/R3 single read from source 0
    setsrc(0, 0, 2, 1, 32'h1000_0040, 0);
    fire(6'b000001);
    chk(s_ready[0] == 1'b0, "R2", "ready low while held", s_ready[0], 0);
    grant_one("R3");
    chk(g_tag == 0, "R3", "tag", g_tag, 0);
    chk(g_addr == 32'h1000_0040, "R3", "address", g_addr, 32'h1000_0040);
    chk(g_size == 2'd2 && g_prio == 2'd1 && !g_we, "R3", "size/prio/we", {g_size, g_prio, g_we}, 5'b10010);
    chk(s_ready[0] == 1'b0, "R2", "ready low while outstanding", s_ready[0], 0);
    respond(0, 0, 32'hCAFE_0001, 1);
    chk(s_ready[0] == 1'b1, "R2", "ready after response", s_ready[0], 1);

    // R4 priority: src1 low, src2 med, src3 high
    setsrc(1, 0, 0, 0, 32'h11, 0);
    setsrc(2, 0, 1, 1, 32'h22, 0);
    setsrc(3, 0, 2, 2, 32'h33, 0);
    fire(6'b001110);
    grant_one("R4"); chk(g_tag == 3, "R4", "first grant", g_tag, 3);
    chk(g_prio == 2'd2, "R3", "priority level high", g_prio, 2);
    grant_one("R4"); chk(g_tag == 2, "R4", "second grant", g_tag, 2);
    grant_one("R4"); chk(g_tag == 1, "R4", "third grant", g_tag, 1);
    respond(1, 0, 32'h1, 1);
    respond(2, 0, 32'h2, 1);
    respond(3, 0, 32'h3, 1);

    // R5 round robin among equal priority, last grant was source 1
    setsrc(0, 0, 1, 1, 32'hA0, 0);
    setsrc(2, 0, 1, 1, 32'hA2, 0);
    setsrc(4, 0, 1, 1, 32'hA4, 0);
    fire(6'b010101);
    grant_one("R5"); chk(g_tag == 2, "R5", "rr first", g_tag, 2);
    grant_one("R5"); chk(g_tag == 4, "R5", "rr second", g_tag, 4);
    grant_one("R5"); chk(g_tag == 0, "R5", "rr wrap", g_tag, 0);
    respond(4, 0, 32'h44, 1);
    respond(0, 0, 32'h40, 1);
    respond(2, 0, 32'h42, 1);

    // R8 out of order: issued 5 then 0, answered 0 then 5
    setsrc(0, 0, 2, 1, 32'hB0, 0);
    setsrc(5, 0, 2, 1, 32'hB5, 0);
    fire(6'b100001);
    grant_one("R8"); chk(g_tag == 5, "R5", "rr after wrap", g_tag, 5);
    grant_one("R8"); chk(g_tag == 0, "R8", "second issue", g_tag, 0);
    respond(0, 0, 32'hD0D0_0000, 1);
    chk(s_ready[5] == 1'b0 && s_ready[0] == 1'b1, "R8", "ready after ooo", s_ready, 6'b011111);
    respond(5, 0, 32'hD5D5_0005, 1);

    // R9 retry
    setsrc(1, 0, 1, 2, 32'h0000_0100, 0);
    fire(6'b000010);
    grant_one("R9"); chk(g_tag == 1, "R9", "first issue", g_tag, 1);
    respond(1, 2, 32'hBAD, 0);
    chk(b_req == 1'b0, "R9", "request dropped after retry", b_req, 0);
    chk(s_ready[1] == 1'b0, "R9", "slot still held", s_ready[1], 0);
    @(negedge clk);
    chk(b_req == 1'b1, "R9", "request again", b_req, 1);
    chk(b_tag == 1 && b_addr == 32'h100 && b_size == 2'd1 && b_prio == 2'd2, "R9",
        "replay fields", {b_tag, b_addr, b_size, b_prio}, {3'd1, 32'h100, 2'd1, 2'd2});
    grant_one("R9");
    respond(1, 0, 32'h7777, 1);

    // R6 hold while waiting for grant
    setsrc(2, 0, 0, 0, 32'hC2, 0);
    fire(6'b000100);
    chk(b_req && b_tag == 2, "R6", "low presented", b_tag, 2);
    @(negedge clk);
    setsrc(3, 0, 2, 2, 32'hC3, 0);
    fire(6'b001000);
    chk(b_req && b_tag == 2 && b_prio == 2'd0 && b_addr == 32'hC2, "R6", "held phase", b_tag, 2);
    grant_one("R6"); chk(g_tag == 2, "R6", "held grant", g_tag, 2);
    grant_one("R4"); chk(g_tag == 3, "R4", "high after hold", g_tag, 3);
    respond(3, 0, 32'h3333, 1);
    respond(2, 0, 32'h2222, 1);

    // R10 spurious response to idle source 4
    rv = 1'b1; rtag = TW'(4); rcode = 2'd0; rdata = 32'h9999;
    #1;
    chk(r_valid == '0, "R10", "no response on spurious", r_valid, 0);
    @(negedge clk);
    rv = 1'b0;
    chk(s_ready[4] == 1'b1, "R10", "ready after spurious", s_ready[4], 1);

    // R3/R7 write with error response
    setsrc(4, 1, 0, 1, 32'h0000_0203, 32'h0000_00A5);
    fire(6'b010000);
    grant_one("R3");
    chk(g_we && g_wdata == 32'hA5 && g_size == 2'd0 && g_tag == 4, "R3", "write phase",
        {g_we, g_wdata, g_size}, {1'b1, 32'hA5, 2'd0});
    respond(4, 1, 32'h0, 1);

    @(negedge clk);
    chk(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);
    chk(b_req == 1'b0 && s_ready == '1, "R2", "idle at end", {b_req, s_ready}, 7'b0111111);
    finish_run();
  end
endmodule